// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave side of a four-wire serial link in front of a 1 KB byte-addressable nonvolatile memory. It runs on the system clock. Select, serial clock and serial data are first passed through synchronisers, and the edges of the serial clock are found by comparing successive synchronised samples. Within one selection the block shifts in a command byte, then, depending on that byte, a 16-bit address and data, always most significant bit first. It turns the result into requests to the memory array and to the status unit. For reads it streams data back on the serial output.

The supported commands are: set the write-enable latch, clear it, read status, write status, read the array, write the array, and write the incrementing-counter area. Any other command byte makes the block drop the rest of the selection. The block only forwards requests. Write protection, the rule that counters may only go upwards, and the latch itself belong to the memory array and the status unit behind it.

Array writes leave through a valid/ready channel. A request stays on the port, unchanged, until the array accepts it. A data byte that completes while the previous request is still waiting is discarded, so the array must accept within eight serial clocks. Status reads and array reads use plain combinational read ports.

Top module: `spi_mem_frontend`

## Requirements
- R1: After reset and whenever select has been high for a few system clocks, `spi_miso_oe` is low. The output is enabled only during a read-array or read-status data phase.
- R2: Command 06h gives exactly one `wel_set` pulse and command 04h exactly one `wel_clr` pulse. After either, all further serial clocks in that selection are ignored: no request, no pulse, no output enable.
- R3: A command byte other than 01h, 02h, 03h, 04h, 05h, 06h and 07h produces no request, no pulse and no output enable for the rest of the selection. The next selection is decoded normally.
- R4: Command 03h is followed by a 16-bit address, most significant bit first, of which bits 15..10 are ignored. The bit sampled on the 25th rising serial edge is bit 7 of the byte at that address. Each later bit changes only after a falling serial edge.
- R5: During a read the byte address advances by one after each byte and wraps from 3FFh to 000h.
- R6: Command 05h streams the status byte repeatedly, bit 7 first, for as long as the master keeps clocking.
- R7: Command 02h with a 16-bit address issues one write request per complete data byte after the address. The address rises by one per byte and wraps at 3FFh, and `mem_wr_incr` is 0. A trailing partial byte issues nothing.
- R8: Command 07h behaves as in R7 but every request carries `mem_wr_incr` = 1.
- R9: While `mem_wr_valid` is high and `mem_wr_ready` is low, address, data and flag hold steady. A byte that completes meanwhile is discarded.
- R10: Command 01h gives one `stat_wr_valid` pulse carrying the data byte when select rises. This happens only if exactly 16 rising serial edges were seen in that selection.
- R11: Select already low when reset is released does not start a command. Only a falling edge of select does.
- R12: Mode 0 (clock idle low) and mode 3 (clock idle high) give identical results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low select from the master |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master (low when not enabled) |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| mem_rd_addr | output | 10 | Array read address |
| mem_rd_data | input | 8 | Array read data, combinational from `mem_rd_addr` |
| mem_wr_valid | output | 1 | Array write request valid |
| mem_wr_ready | input | 1 | Array accepts the write request |
| mem_wr_addr | output | 10 | Write request address |
| mem_wr_data | output | 8 | Write request data |
| mem_wr_incr | output | 1 | Request targets the incrementing-counter area |
| stat_rd_data | input | 8 | Current status byte |
| stat_wr_valid | output | 1 | One-cycle status write pulse |
| stat_wr_data | output | 8 | New status byte |
| wel_set | output | 1 | One-cycle pulse: set write-enable latch |
| wel_clr | output | 1 | One-cycle pulse: clear write-enable latch |

## Verification
Every one of the 249 undefined command bytes is sent, each followed by more clocking, to show that nothing reaches any port. The latch commands are followed by a byte that would otherwise be a status read, which tells a real halt apart from a decoder that merely restarts. Reads start at addresses with junk upper bits and at the top of the array, which separates correct address masking and wrap from a plain counter. Writes are sent complete, partial and against a stalled ready, and status writes with exact, long and short lengths, in both clock modes.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam logic [7:0] OP_WEL_SET = 8'h06;
  localparam logic [7:0] OP_WEL_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD = 8'h05;
  localparam logic [7:0] OP_STAT_WR = 8'h01;
  localparam logic [7:0] OP_ARR_RD  = 8'h03;
  localparam logic [7:0] OP_ARR_WR  = 8'h02;
  localparam logic [7:0] OP_CNT_WR  = 8'h07;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_ARR_RD,
    ST_ARR_WR,
    ST_STAT_RD,
    ST_STAT_WR,
    ST_HALT
  } fe_state_e;
endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else if (s == 0) chain_q[s] <= d;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/fe_tx_shift.sv
module fe_tx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  output logic              bit_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= din;
    else if (shift) sh_q <= {sh_q[DATA_W-2:0], 1'b0};
  end

  assign bit_o = sh_q[DATA_W-1];
endmodule

// File: rtl/fe_cmd_ctrl.sv
module fe_cmd_ctrl
  import fe_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 8,
  parameter int CMD_ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic [DATA_W-1:0] stat_rd_data,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_incr,
  output logic              stat_wr_valid,
  output logic [DATA_W-1:0] stat_wr_data,
  output logic              wel_set,
  output logic              wel_clr,
  output logic              tx_load,
  output logic              tx_shift,
  output logic [DATA_W-1:0] tx_data,
  output logic              out_en
);
  localparam int CNT_W      = $clog2(DATA_W);
  localparam int ADDR_BYTES = CMD_ADDR_W / DATA_W;
  localparam int AB_W       = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  fe_state_e         state_q;
  logic [DATA_W-2:0] rx_q;
  logic [CNT_W-1:0]  bit_q;
  logic [AB_W-1:0]   abyte_q;
  logic [ADDR_W-1:0] addr_q;
  logic              is_wr_q, incr_q, sr_got_q, sr_bad_q;

  wire [DATA_W-1:0] rx_byte   = {rx_q, mosi_s};
  wire              byte_done = (bit_q == CNT_W'(DATA_W-1));
  wire              shifting  = state_q inside {ST_CMD, ST_ADDR, ST_ARR_RD, ST_ARR_WR,
                                                ST_STAT_RD, ST_STAT_WR};
  wire              out_phase = (state_q == ST_ARR_RD) || (state_q == ST_STAT_RD);
  wire              fall_act  = !cs_rise && !cs_fall && sck_fall && out_phase;

  // Output byte boundary: load on the falling edge that follows a full byte.
  always_comb begin
    tx_load  = fall_act && (bit_q == '0);
    tx_shift = fall_act && (bit_q != '0);
    tx_data  = (state_q == ST_ARR_RD) ? mem_rd_data : stat_rd_data;
  end

  assign rd_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; rx_q <= '0; bit_q <= '0; abyte_q <= '0; addr_q <= '0;
      is_wr_q <= 1'b0; incr_q <= 1'b0; sr_got_q <= 1'b0; sr_bad_q <= 1'b0;
      wr_valid <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_incr <= 1'b0;
      stat_wr_valid <= 1'b0; stat_wr_data <= '0;
      wel_set <= 1'b0; wel_clr <= 1'b0; out_en <= 1'b0;
    end else begin
      wel_set       <= 1'b0;
      wel_clr       <= 1'b0;
      stat_wr_valid <= 1'b0;
      if (wr_valid && wr_ready) wr_valid <= 1'b0;

      if (cs_rise) begin
        if (state_q == ST_STAT_WR && sr_got_q && !sr_bad_q && bit_q == '0)
          stat_wr_valid <= 1'b1;
        state_q <= ST_IDLE;
        out_en  <= 1'b0;
      end else if (cs_fall) begin
        state_q  <= ST_CMD;
        bit_q    <= '0;
        rx_q     <= '0;
        abyte_q  <= '0;
        sr_got_q <= 1'b0;
        sr_bad_q <= 1'b0;
        out_en   <= 1'b0;
      end else if (sck_rise && shifting) begin
        rx_q  <= rx_byte[DATA_W-2:0];
        bit_q <= bit_q + 1'b1;
        if (state_q == ST_STAT_WR && sr_got_q) sr_bad_q <= 1'b1;
        if (byte_done) begin
          unique case (state_q)
            ST_CMD: begin
              case (rx_byte)
                OP_WEL_SET: begin wel_set <= 1'b1; state_q <= ST_HALT; end
                OP_WEL_CLR: begin wel_clr <= 1'b1; state_q <= ST_HALT; end
                OP_STAT_RD: state_q <= ST_STAT_RD;
                OP_STAT_WR: state_q <= ST_STAT_WR;
                OP_ARR_RD:  begin state_q <= ST_ADDR; is_wr_q <= 1'b0; incr_q <= 1'b0; end
                OP_ARR_WR:  begin state_q <= ST_ADDR; is_wr_q <= 1'b1; incr_q <= 1'b0; end
                OP_CNT_WR:  begin state_q <= ST_ADDR; is_wr_q <= 1'b1; incr_q <= 1'b1; end
                default:    state_q <= ST_HALT;
              endcase
            end
            ST_ADDR: begin
              addr_q <= ADDR_W'({addr_q, rx_byte});
              if (abyte_q == AB_W'(ADDR_BYTES-1))
                state_q <= is_wr_q ? ST_ARR_WR : ST_ARR_RD;
              else
                abyte_q <= abyte_q + 1'b1;
            end
            ST_ARR_WR: begin
              if (!wr_valid || wr_ready) begin
                wr_valid <= 1'b1;
                wr_addr  <= addr_q;
                wr_data  <= rx_byte;
                wr_incr  <= incr_q;
              end
              addr_q <= addr_q + 1'b1;
            end
            ST_STAT_WR: begin
              if (!sr_got_q) begin
                sr_got_q     <= 1'b1;
                stat_wr_data <= rx_byte;
              end
            end
            default: ;
          endcase
        end
      end else if (fall_act && bit_q == '0) begin
        out_en <= 1'b1;
        if (state_q == ST_ARR_RD) addr_q <= addr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend #(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int CMD_ADDR_W  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              mem_wr_incr,
  input  logic [DATA_W-1:0] stat_rd_data,
  output logic              stat_wr_valid,
  output logic [DATA_W-1:0] stat_wr_data,
  output logic              wel_set,
  output logic              wel_clr
);
  logic [2:0] pins_s;
  logic [1:0] edge_prev_q;
  logic       cs_rise, cs_fall, sck_rise, sck_fall;
  logic       tx_load, tx_shift, tx_bit, out_en;
  logic [DATA_W-1:0] tx_data;

  fe_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_mosi, spi_sck, spi_cs_n}),
    .q(pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_prev_q <= '0;
    else        edge_prev_q <= pins_s[1:0];
  end

  assign cs_rise  =  pins_s[0] & ~edge_prev_q[0];
  assign cs_fall  = ~pins_s[0] &  edge_prev_q[0];
  assign sck_rise =  pins_s[1] & ~edge_prev_q[1];
  assign sck_fall = ~pins_s[1] &  edge_prev_q[1];

  fe_cmd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR_W(CMD_ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .mosi_s(pins_s[2]),
    .mem_rd_data(mem_rd_data), .stat_rd_data(stat_rd_data), .wr_ready(mem_wr_ready),
    .rd_addr(mem_rd_addr),
    .wr_valid(mem_wr_valid), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data),
    .wr_incr(mem_wr_incr),
    .stat_wr_valid(stat_wr_valid), .stat_wr_data(stat_wr_data),
    .wel_set(wel_set), .wel_clr(wel_clr),
    .tx_load(tx_load), .tx_shift(tx_shift), .tx_data(tx_data), .out_en(out_en)
  );

  fe_tx_shift #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .shift(tx_shift),
    .din(tx_data), .bit_o(tx_bit)
  );

  assign spi_miso_oe = out_en;
  assign spi_miso    = tx_bit & out_en;
endmodule

// File: rtl/fe_checker.sv
module fe_checker #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_rise,
  input logic              sck_fall,
  input logic              spi_miso,
  input logic              spi_miso_oe,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              mem_wr_incr,
  input logic              stat_wr_valid,
  input logic              wel_set,
  input logic              wel_clr
);
  // R1: a detected deselect disables the output on the next cycle
  assert_oe_off_after_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !spi_miso_oe);

  // R2: latch commands are single pulses and never together
  assert_wel_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wel_set && wel_clr));
  assert_wel_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wel_set || wel_clr) |=> !(wel_set || wel_clr));

  // R4: while driven, the serial output changes only after a falling serial edge
  assert_miso_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_miso_oe && $past(spi_miso_oe) && !$stable(spi_miso)) |-> $past(sck_fall));

  // R9: a stalled write request holds its contents
  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data) && $stable(mem_wr_incr)));

  // R10: a status write is issued only right after a deselect
  assert_stat_wr_on_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_valid |-> $past(cs_rise));
endmodule

bind spi_mem_frontend fe_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fe_checker (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .sck_fall(sck_fall),
  .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
  .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_incr(mem_wr_incr),
  .stat_wr_valid(stat_wr_valid), .wel_set(wel_set), .wel_clr(wel_clr)
);

// File: tb/test_spi_mem_frontend.sv
`timescale 1ns/1ps
module test_spi_mem_frontend;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe;
  logic [9:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data, stat_rd, stat_wd;
  logic wr_valid, wr_ready, wr_incr, stat_wv, wset, wclr;

  int n_chk = 0, n_fail = 0;
  int n_set = 0, n_clr = 0, n_swr = 0, n_oe = 0, n_oe_bad = 0, cs_hi_run = 0;
  logic [7:0] last_swd;
  int wq_n = 0;
  logic [9:0] wq_a [32];
  logic [7:0] wq_d [32];
  logic       wq_i [32];
  logic       mode3 = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [7:0] fdat(input logic [9:0] a);
    return 8'(a * 37 + 11) ^ 8'(a >> 3);
  endfunction

  assign rd_data = fdat(rd_addr);

  spi_mem_frontend i_spi_mem_frontend (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe),
    .mem_rd_addr(rd_addr), .mem_rd_data(rd_data),
    .mem_wr_valid(wr_valid), .mem_wr_ready(wr_ready), .mem_wr_addr(wr_addr),
    .mem_wr_data(wr_data), .mem_wr_incr(wr_incr),
    .stat_rd_data(stat_rd), .stat_wr_valid(stat_wv), .stat_wr_data(stat_wd),
    .wel_set(wset), .wel_clr(wclr)
  );

  always @(negedge clk) begin
    if (wr_valid && wr_ready && wq_n < 32) begin
      wq_a[wq_n] = wr_addr; wq_d[wq_n] = wr_data; wq_i[wq_n] = wr_incr; wq_n++;
    end
    if (wset) n_set++;
    if (wclr) n_clr++;
    if (stat_wv) begin n_swr++; last_swd = stat_wd; end
    if (miso_oe) n_oe++;
    cs_hi_run = cs_n ? cs_hi_run + 1 : 0;
    if (miso_oe && cs_hi_run > 8) n_oe_bad++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_frame();
    sck = mode3; ticks(HALF); cs_n = 1'b0; ticks(HALF);
  endtask

  task automatic end_frame();
    ticks(HALF); cs_n = 1'b1; ticks(4 * HALF);
  endtask

  task automatic sbit(input logic b, output logic r);
    if (mode3) sck = 1'b0;
    mosi = b; ticks(HALF);
    sck = 1'b1; r = miso; ticks(HALF);
    if (!mode3) sck = 1'b0;
  endtask

  task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      sbit(tx[i], b);
      rx[i] = b;
    end
  endtask

  task automatic do_read(input logic [15:0] a, input int n, input string req);
    logic [7:0] r;
    begin_frame();
    sbyte(8'h03, r); sbyte(a[15:8], r); sbyte(a[7:0], r);
    for (int k = 0; k < n; k++) begin
      sbyte(8'h00, r);
      chk(req, r, fdat(10'(a[9:0] + k)));
    end
    end_frame();
  endtask

  task automatic do_write(input logic [7:0] op, input logic [15:0] a,
                          input logic [7:0] d0, input int n, input int extra_bits);
    logic [7:0] r;
    logic b;
    begin_frame();
    sbyte(op, r); sbyte(a[15:8], r); sbyte(a[7:0], r);
    for (int k = 0; k < n; k++) sbyte(8'(d0 + k), r);
    for (int k = 0; k < extra_bits; k++) sbit(1'b1, b);
    end_frame();
  endtask

  task automatic run_mode(input logic m);
    logic [7:0] r;
    logic b;
    int s0, c0, o0, w0, f0;
    string tag;
    mode3 = m;
    tag = m ? "mode3" : "mode0";

    // R2: set latch, then would-be status read must be ignored
    s0 = n_set; o0 = n_oe; c0 = n_clr;
    begin_frame(); sbyte(8'h06, r); sbyte(8'h05, r); sbyte(8'h01, r); end_frame();
    chk({"R2 set pulse ", tag}, n_set - s0, 1);
    chk({"R2 halt after set ", tag}, {n_oe - o0, n_clr - c0}, 0);
    begin_frame(); sbyte(8'h04, r); sbyte(8'h06, r); end_frame();
    chk({"R2 clear pulse ", tag}, n_clr - c0, 1);
    chk({"R2 halt after clear ", tag}, n_set - s0, 1);

    // R4 R5: reads with junk upper address bits and wrap
    do_read(16'hFC00, 3, {"R4 read base ", tag});
    do_read(16'h5555, 2, {"R4 read masked ", tag});
    do_read(16'h03FD, 5, {"R5 read wrap ", tag});

    // R6: status streaming
    stat_rd = m ? 8'h3C : 8'hA5;
    begin_frame(); sbyte(8'h05, r);
    for (int k = 0; k < 3; k++) begin
      sbyte(8'h00, r);
      chk({"R6 status stream ", tag}, r, stat_rd);
    end
    end_frame();

    // R7: array write with wrap, then a partial byte
    w0 = wq_n;
    do_write(8'h02, 16'hC3FE, 8'h40, 3, 5);
    chk({"R7 write count ", tag}, wq_n - w0, 3);
    for (int k = 0; k < 3; k++)
      chk({"R7 write req ", tag}, {wq_a[w0+k], wq_d[w0+k], wq_i[w0+k]},
          {10'(10'h3FE + k), 8'(8'h40 + k), 1'b0});

    // R8: counter-area write
    w0 = wq_n;
    do_write(8'h07, 16'h0010, 8'h90, 2, 0);
    chk({"R8 counter count ", tag}, wq_n - w0, 2);
    for (int k = 0; k < 2; k++)
      chk({"R8 counter req ", tag}, {wq_a[w0+k], wq_d[w0+k], wq_i[w0+k]},
          {10'(10'h010 + k), 8'(8'h90 + k), 1'b1});

    // R10: status write exact, long, short
    f0 = n_swr;
    begin_frame(); sbyte(8'h01, r); sbyte(m ? 8'h8C : 8'h71, r); end_frame();
    chk({"R10 status write ", tag}, {n_swr - f0, 24'(last_swd)},
        {1, 24'(m ? 8'h8C : 8'h71)});
    begin_frame(); sbyte(8'h01, r); sbyte(8'h22, r);
    for (int k = 0; k < 3; k++) sbit(1'b0, b);
    end_frame();
    begin_frame(); sbyte(8'h01, r);
    for (int k = 0; k < 4; k++) sbit(1'b0, b);
    end_frame();
    chk({"R10 wrong length ", tag}, n_swr - f0, 1);

    // R3: a few undefined command bytes in this mode
    s0 = n_set + n_clr + n_swr + wq_n; o0 = n_oe;
    begin_frame(); sbyte(8'hFF, r); sbyte(8'h05, r); end_frame();
    begin_frame(); sbyte(8'h00, r); sbyte(8'h03, r); end_frame();
    chk({"R3 undefined ", tag}, {n_set + n_clr + n_swr + wq_n - s0, n_oe - o0}, 0);
  endtask

  initial begin
    logic [7:0] r;
    int s0, o0, w0;
    wr_ready = 1'b1; stat_rd = 8'h00;
    ticks(5);
    rst_n = 1'b1;
    ticks(4);
    // R1: reset state
    chk("R1 reset outputs", {miso_oe, wr_valid, stat_wv, wset, wclr}, 0);
    // R11: select already low at reset release starts nothing
    sbyte(8'h06, r); sbyte(8'h05, r);
    chk("R11 no command without select edge", {n_set, n_oe}, 0);
    cs_n = 1'b1; ticks(4 * HALF);

    run_mode(1'b0);
    run_mode(1'b1);   // R12: same sequence in the other clock mode
    mode3 = 1'b0;

    // R9: stalled write channel
    wr_ready = 1'b0; w0 = wq_n;
    do_write(8'h02, 16'h0020, 8'h11, 2, 0);
    chk("R9 held request", {wr_valid, wr_addr, wr_data}, {1'b1, 10'h020, 8'h11});
    wr_ready = 1'b1; ticks(4);
    chk("R9 second byte dropped", {wq_n - w0, wq_d[w0]}, {32'd1, 8'h11});

    // R3: sweep all undefined command bytes
    for (int op = 0; op < 256; op++) begin
      if (op >= 1 && op <= 7) continue;
      s0 = n_set + n_clr + n_swr + wq_n; o0 = n_oe;
      begin_frame(); sbyte(8'(op), r); sbyte(8'h05, r); end_frame();
      chk($sformatf("R3 undefined %02h", op), {n_set + n_clr + n_swr + wq_n - s0, n_oe - o0}, 0);
    end
    // R3: recovery on the next selection
    stat_rd = 8'h6E;
    begin_frame(); sbyte(8'h05, r); sbyte(8'h00, r); end_frame();
    chk("R3 decode after undefined", r, 8'h6E);

    chk("R1 output off while deselected", n_oe_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule